// File: doc/BRIEF.md
# Receive Polarity Auto-Correction Controller

This block sits beside the receive decoder of each twisted-pair port. It watches for packets whose data arrived with reversed wire polarity and, when software has enabled the feature for that port, sets a control bit that inverts the receive data path. It also raises a status bit for as long as the inversion is active.

The decision is one-shot. The first valid packet after re-arming settles the port's polarity as either normal or inverted. Later packets cannot change that result. The controller re-arms only through reset, a link-fail indication, or software clearing the port's enable. Runt and collision fragments, which the decoder flags as not valid, never count as the deciding packet.

All ports share one parameterised instance. Each port has its own independent state machine.

Top module: `pol_auto_corr`

## Requirements
- R1: After reset, every port is armed, with `rx_invert_o` and `corr_stat_o` low.
- R2: An armed, enabled port sets `rx_invert_o` high in the cycle after a valid packet end (`pkt_end_i`=1 and `pkt_ok_i`=1) that has `pkt_inv_i`=1, where 1 means inverted polarity.
- R3: If the first valid packet after arming has `pkt_inv_i`=0, the port locks to normal polarity. Later inverted packets leave `rx_invert_o` low until the port is re-armed.
- R4: Once `rx_invert_o` is high, later packet ends of any kind do not clear or toggle it while the port stays enabled and the link is not failed.
- R5: A packet end with `pkt_ok_i`=0 (runt or collision fragment) is ignored and does not use up the one decision.
- R6: While `enable_i` is low, the port stays armed and ignores packets. Driving `enable_i` low clears `rx_invert_o` in the next cycle.
- R7: `link_fail_i` high clears `rx_invert_o` in the next cycle and re-arms the port. It takes priority over a packet end in the same cycle.
- R8: `corr_stat_o` equals `rx_invert_o` on every port at all times.
- R9: Events on one port never change the outputs of another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | N_PORTS | Per-port auto-correction enable |
| pkt_end_i | input | N_PORTS | End-of-packet strobe from the receive decoder |
| pkt_ok_i | input | N_PORTS | Packet was valid (not a runt or collision fragment) |
| pkt_inv_i | input | N_PORTS | Packet was received with inverted polarity (1 = inverted) |
| link_fail_i | input | N_PORTS | Link failure indication; re-arms the port |
| rx_invert_o | output | N_PORTS | Invert control for the receive data path |
| corr_stat_o | output | N_PORTS | Status: correction currently applied |

## Verification
The hardest situation to reach is a later packet arriving after the decision has been latched. This matters most when the first valid packet was preceded by fragments, because a bug would let a fragment or a second packet overwrite the choice. To reach it, the bench re-arms each port with a link-fail pulse and then sweeps every ordered triple of runt, normal and inverted packets. A small behavioural model predicts the locked result of each triple. Further directed cases place a link fail in the same cycle as an inverted packet, and drop the enable while the inversion is latched.

// File: rtl/pol_pkg.sv
package pol_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_NORM  = 2'd1,
    ST_INV   = 2'd2
  } pol_st_e;
endpackage

// File: rtl/pol_qual.sv
// Qualifies decoder events for one port.
module pol_qual (
  input  logic en_i,
  input  logic lf_i,
  input  logic end_i,
  input  logic ok_i,
  input  logic inv_i,
  output logic rearm_o,
  output logic take_o,
  output logic take_inv_o
);
  always_comb begin
    rearm_o    = lf_i | ~en_i;
    // re-arm wins over a packet in the same cycle
    take_o     = ~rearm_o & end_i & ok_i;
    take_inv_o = take_o & inv_i;
  end
endmodule

// File: rtl/pol_port_fsm.sv
module pol_port_fsm
  import pol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rearm_i,
  input  logic take_i,
  input  logic take_inv_i,
  output logic invert_o,
  output logic stat_o
);
  pol_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rearm_i) begin
      st_d = ST_ARMED;
    end else begin
      unique case (st_q)
        ST_ARMED: if (take_i) st_d = take_inv_i ? ST_INV : ST_NORM;
        ST_NORM:  st_d = ST_NORM;
        ST_INV:   st_d = ST_INV;
        default:  st_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_ARMED;
      invert_o <= 1'b0;
      stat_o   <= 1'b0;
    end else begin
      st_q     <= st_d;
      invert_o <= (st_d == ST_INV);
      stat_o   <= (st_d == ST_INV);
    end
  end
endmodule

// File: rtl/pol_auto_corr.sv
module pol_auto_corr #(
  parameter int N_PORTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] enable_i,
  input  logic [N_PORTS-1:0] pkt_end_i,
  input  logic [N_PORTS-1:0] pkt_ok_i,
  input  logic [N_PORTS-1:0] pkt_inv_i,
  input  logic [N_PORTS-1:0] link_fail_i,
  output logic [N_PORTS-1:0] rx_invert_o,
  output logic [N_PORTS-1:0] corr_stat_o
);
  logic [N_PORTS-1:0] rearm, take, take_inv;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    pol_qual u_qual (
      .en_i       (enable_i[p]),
      .lf_i       (link_fail_i[p]),
      .end_i      (pkt_end_i[p]),
      .ok_i       (pkt_ok_i[p]),
      .inv_i      (pkt_inv_i[p]),
      .rearm_o    (rearm[p]),
      .take_o     (take[p]),
      .take_inv_o (take_inv[p])
    );
    pol_port_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rearm_i    (rearm[p]),
      .take_i     (take[p]),
      .take_inv_i (take_inv[p]),
      .invert_o   (rx_invert_o[p]),
      .stat_o     (corr_stat_o[p])
    );
  end
endmodule

// File: rtl/pol_auto_corr_chk.sv
module pol_auto_corr_chk #(
  parameter int N_PORTS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_PORTS-1:0] enable_i,
  input logic [N_PORTS-1:0] pkt_end_i,
  input logic [N_PORTS-1:0] pkt_ok_i,
  input logic [N_PORTS-1:0] pkt_inv_i,
  input logic [N_PORTS-1:0] link_fail_i,
  input logic [N_PORTS-1:0] rx_invert_o,
  input logic [N_PORTS-1:0] corr_stat_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    assert_set_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_invert_o[p]) |-> $past(enable_i[p] && !link_fail_i[p] &&
                                      pkt_end_i[p] && pkt_ok_i[p] && pkt_inv_i[p]));
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_invert_o[p] && enable_i[p] && !link_fail_i[p]) |=> rx_invert_o[p]);
    assert_disable_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i[p] |=> !rx_invert_o[p]);
    assert_lf_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_fail_i[p] |=> !rx_invert_o[p]);
    assert_stat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corr_stat_o[p] == rx_invert_o[p]);
    assert_runt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rx_invert_o[p] && !(pkt_end_i[p] && pkt_ok_i[p])) |=> !rx_invert_o[p]);
  end
endmodule

bind pol_auto_corr pol_auto_corr_chk #(.N_PORTS(N_PORTS)) u_chk (.*);

// File: tb/sim_pol_auto_corr.sv
`timescale 1ns/1ps
module sim_pol_auto_corr;
  localparam int NP = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0] enable_i = '0, pkt_end_i = '0, pkt_ok_i = '0, pkt_inv_i = '0, link_fail_i = '0;
  logic [NP-1:0] rx_invert_o, corr_stat_o;

  int n_tests = 0, n_fail = 0;
  int exp_st [NP];  // 0 armed, 1 normal, 2 inverted

  always #2 clk_i = ~clk_i;

  pol_auto_corr #(.N_PORTS(NP)) u0 (.*);

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check_all(input int p_act, input string req);
    for (int q = 0; q < NP; q++) begin
      string tag = (q == p_act) ? req : "R9";
      logic e = (exp_st[q] == 2);
      n_tests++;
      if (rx_invert_o[q] !== e) begin
        n_fail++;
        $display("FAIL %s port %0d invert actual %b expected %b", tag, q, rx_invert_o[q], e);
      end
      n_tests++;
      if (corr_stat_o[q] !== e) begin
        n_fail++;
        $display("FAIL R8 port %0d status actual %b expected %b", q, corr_stat_o[q], e);
      end
    end
  endtask

  // one cycle of stimulus on port p, then check after the edge
  task automatic apply(input int p, input logic en, input logic lf,
                       input logic pe, input logic ok, input logic inv, input string req);
    @(negedge clk_i);
    enable_i[p] = en; link_fail_i[p] = lf;
    pkt_end_i[p] = pe; pkt_ok_i[p] = ok; pkt_inv_i[p] = inv;
    if (lf || !en) exp_st[p] = 0;
    else if (exp_st[p] == 0 && pe && ok) exp_st[p] = inv ? 2 : 1;
    @(negedge clk_i);
    link_fail_i[p] = 1'b0; pkt_end_i[p] = 1'b0; pkt_ok_i[p] = 1'b0; pkt_inv_i[p] = 1'b0;
    check_all(p, req);
  endtask

  // kind: 0 runt inverted, 1 valid normal, 2 valid inverted
  task automatic pkt(input int p, input int kind);
    string r = (kind == 0) ? "R5" : (exp_st[p] == 1) ? "R3" : (exp_st[p] == 2) ? "R4" : "R2";
    apply(p, 1'b1, 1'b0, 1'b1, kind != 0, kind != 1, r);
  endtask

  initial begin
    for (int q = 0; q < NP; q++) exp_st[q] = 0;
    #7;
    check_all(0, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all(0, "R1");

    // R6: disabled port ignores an inverted packet
    apply(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
    enable_i = '1;

    // sweep all triples per port, re-armed by link fail (R7)
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++) begin
            apply(p, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
            pkt(p, a); pkt(p, b); pkt(p, c);
          end

    // R7: link fail in same cycle as inverted packet wins
    for (int p = 0; p < NP; p++) begin
      apply(p, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
      pkt(p, 2);
      // R6: dropping enable clears and re-arms
      apply(p, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      apply(p, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
      pkt(p, 1);
      pkt(p, 2);
      apply(p, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      pkt(p, 2);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule